// File: doc/BRIEF.md
# Calendar Time Counter

This block keeps wall-clock time and date in eight separate counters: seconds, minutes, hours, weekday, day of month, day of year, month and year. Each count-enable pulse on `tick` (normally once per second) moves the time forward by one second. Each wrap carries into the next field on the same pulse. Month lengths follow the calendar, and February gets a 29th day when the year is a multiple of four.

Software reaches the block over a simple synchronous register bus. The bus uses byte addresses, and every register is one 32-bit word. Each counter has its own read/write word. Three read-only summary words carry all counters at fixed bit positions, so a reader can fetch the full time in three accesses. The summary words are assembled combinationally from the live counters, so each word shows values from a single clock cycle. A control word holds a run bit that freezes all counting while software loads a new time. It also holds one spare flag that is stored and read back and has no other effect.

Top module: `calendar_clock`

## Requirements
- R1: After reset, every counter reads as follows: seconds, minutes, hours, weekday and year read 0; day of month, day of year and month read 1. The control word reads 0, so counting is stopped.
- R2: The control word is at 0x08, and its bit 0 is the run bit. While the run bit is 0, `tick` changes no counter.
- R3: Bit 4 of the control word is stored and read back and does not affect counting. The other control bits read 0.
- R4: The counters are read/write words at these offsets: 0x20 seconds (6 bits), 0x24 minutes (6), 0x28 hours (5), 0x2C day of month (5), 0x30 weekday (3), 0x34 day of year (9), 0x38 month (4), 0x3C year (12). A write stores the low bits of the data, and the upper bits read 0.
- R5: While the run bit is 1, each `tick` advances seconds. Seconds wrap from 59 to 0 and carry into minutes, and minutes wrap from 59 to 0 and carry into hours, all on the same tick.
- R6: Hours wrap from 23 to 0, and that day boundary advances the weekday, which wraps from 6 to 0.
- R7: At a day boundary, day of month advances until it reaches the month length, then returns to 1 and advances the month. Months 4, 6, 9 and 11 have 30 days; month 2 has 29 days when year mod 4 is 0 and 28 otherwise; all other months have 31 days.
- R8: Day of year advances at each day boundary. After month 12 ends, day of year returns to 1, month returns to 1 and year increments.
- R9: The summary word at 0x14 holds seconds in bits 5:0, minutes in 13:8, hours in 20:16 and weekday in 26:24. All other bits read 0.
- R10: The summary word at 0x18 holds day of month in bits 4:0, month in 11:8 and year in 27:16. The summary word at 0x1C holds day of year in bits 11:0. All other bits read 0.
- R11: Writes to 0x14, 0x18 and 0x1C change nothing.
- R12: If a counter write and an advancing tick fall in the same cycle, the written counter takes the written value. All other counters advance using the carries computed from the pre-write values.
- R13: Offsets that are not listed read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second count enable, one cycle wide |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 8 | Byte address of the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |

## Verification
The hardest conditions to reach from the ports are the month, leap-February and year-end rollovers, because running from reset would take millions of ticks. The bench gets there by loading 23:59:59 before each tick, so every tick crosses a day boundary. It walks day by day through one common year and one leap year, and checks the result against a calendar model computed in the bench. A separate sweep of several thousand plain ticks covers the seconds and minutes carries. A tick that coincides with a counter write is driven directly on the same edge.

// File: rtl/calendar_pkg.sv
`timescale 1ns/1ps
package calendar_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HOUR_W   = 5;
  localparam int WDAY_W   = 3;
  localparam int MDAY_W   = 5;
  localparam int YDAY_W   = 9;
  localparam int MON_W    = 4;
  localparam int YEAR_W   = 12;
  localparam int NUM_FIELDS = 8;

  // word offsets whose positions the bus decoder depends on
  localparam logic [ADDR_W-1:0] CTRL_OFS  = 8'h08;
  localparam logic [ADDR_W-1:0] SUM0_OFS  = 8'h14;
  localparam logic [ADDR_W-1:0] SUM1_OFS  = 8'h18;
  localparam logic [ADDR_W-1:0] SUM2_OFS  = 8'h1C;
  localparam logic [ADDR_W-1:0] FIELD_OFS = 8'h20;

  // field index = (offset - FIELD_OFS) / 4
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_MDAY = 3;
  localparam int F_WDAY = 4;
  localparam int F_YDAY = 5;
  localparam int F_MON  = 6;
  localparam int F_YEAR = 7;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [MIN_W-1:0]  min;
    logic [HOUR_W-1:0] hour;
    logic [WDAY_W-1:0] wday;
    logic [MDAY_W-1:0] mday;
    logic [YDAY_W-1:0] yday;
    logic [MON_W-1:0]  mon;
    logic [YEAR_W-1:0] year;
  } calTime_t;

  typedef struct packed {
    logic                  advance;
    logic [NUM_FIELDS-1:0] fieldWr;
  } calStrobes_t;

  function automatic logic [MDAY_W-1:0] monthLength(input logic [MON_W-1:0] mon,
                                                     input logic [YEAR_W-1:0] year);
    logic [MDAY_W-1:0] len;
    case (mon)
      4'd2:                       len = (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:    len = 5'd30;
      default:                    len = 5'd31;
    endcase
    return len;
  endfunction
endpackage

// File: rtl/calendar_ctrl.sv
`timescale 1ns/1ps
module calendar_ctrl
  import calendar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              runBitIn,
  input  logic              spareBitIn,
  output calStrobes_t       strobes,
  output logic              runEn,
  output logic              spareFlag
);
  logic                  wrEn;
  logic [NUM_FIELDS-1:0] fieldHit;

  assign wrEn = busSel && busWr;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fieldDecode
    assign fieldHit[i] = wrEn && (busAddr == FIELD_OFS + ADDR_W'(4 * i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn     <= 1'b0;
      spareFlag <= 1'b0;
    end else if (wrEn && busAddr == CTRL_OFS) begin
      runEn     <= runBitIn;
      spareFlag <= spareBitIn;
    end
  end

  always_comb begin
    strobes.advance = tick && runEn;
    strobes.fieldWr = fieldHit;
  end
endmodule

// File: rtl/calendar_datapath.sv
`timescale 1ns/1ps
module calendar_datapath
  import calendar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calStrobes_t       strobes,
  input  logic [YEAR_W-1:0] wrData,
  output calTime_t          curTime
);
  calTime_t timeQ, stepped, timeD;
  logic secEnd, minEnd, hourEnd;
  logic dayEnd, monthEnd, yearEnd;

  always_comb begin
    secEnd   = timeQ.sec  >= SEC_W'(59);
    minEnd   = timeQ.min  >= MIN_W'(59);
    hourEnd  = timeQ.hour >= HOUR_W'(23);
    dayEnd   = secEnd && minEnd && hourEnd;
    monthEnd = dayEnd && (timeQ.mday >= monthLength(timeQ.mon, timeQ.year));
    yearEnd  = monthEnd && (timeQ.mon >= MON_W'(12));
  end

  always_comb begin
    stepped = timeQ;
    stepped.sec = secEnd ? '0 : timeQ.sec + 1'b1;
    if (secEnd)
      stepped.min = minEnd ? '0 : timeQ.min + 1'b1;
    if (secEnd && minEnd)
      stepped.hour = hourEnd ? '0 : timeQ.hour + 1'b1;
    if (dayEnd) begin
      stepped.wday = (timeQ.wday >= WDAY_W'(6)) ? '0 : timeQ.wday + 1'b1;
      stepped.mday = monthEnd ? MDAY_W'(1) : timeQ.mday + 1'b1;
      stepped.yday = yearEnd  ? YDAY_W'(1) : timeQ.yday + 1'b1;
    end
    if (monthEnd)
      stepped.mon = yearEnd ? MON_W'(1) : timeQ.mon + 1'b1;
    if (yearEnd)
      stepped.year = timeQ.year + 1'b1;
  end

  always_comb begin
    timeD = strobes.advance ? stepped : timeQ;
    if (strobes.fieldWr[F_SEC])  timeD.sec  = wrData[SEC_W-1:0];
    if (strobes.fieldWr[F_MIN])  timeD.min  = wrData[MIN_W-1:0];
    if (strobes.fieldWr[F_HOUR]) timeD.hour = wrData[HOUR_W-1:0];
    if (strobes.fieldWr[F_MDAY]) timeD.mday = wrData[MDAY_W-1:0];
    if (strobes.fieldWr[F_WDAY]) timeD.wday = wrData[WDAY_W-1:0];
    if (strobes.fieldWr[F_YDAY]) timeD.yday = wrData[YDAY_W-1:0];
    if (strobes.fieldWr[F_MON])  timeD.mon  = wrData[MON_W-1:0];
    if (strobes.fieldWr[F_YEAR]) timeD.year = wrData[YEAR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeQ      <= '0;
      timeQ.mday <= MDAY_W'(1);
      timeQ.yday <= YDAY_W'(1);
      timeQ.mon  <= MON_W'(1);
    end else begin
      timeQ <= timeD;
    end
  end

  assign curTime = timeQ;
endmodule

// File: rtl/calendar_readout.sv
`timescale 1ns/1ps
module calendar_readout
  import calendar_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  calTime_t          curTime,
  input  logic              runEn,
  input  logic              spareFlag,
  output logic [DATA_W-1:0] busRdata
);
  logic [DATA_W-1:0] sum0, sum1, sum2, ctrlWord;

  always_comb begin
    sum0 = '0;
    sum0[SEC_W-1:0]        = curTime.sec;
    sum0[8 +: MIN_W]       = curTime.min;
    sum0[16 +: HOUR_W]     = curTime.hour;
    sum0[24 +: WDAY_W]     = curTime.wday;
    sum1 = '0;
    sum1[MDAY_W-1:0]       = curTime.mday;
    sum1[8 +: MON_W]       = curTime.mon;
    sum1[16 +: YEAR_W]     = curTime.year;
    sum2 = '0;
    sum2[YDAY_W-1:0]       = curTime.yday;
    ctrlWord = '0;
    ctrlWord[0]            = runEn;
    ctrlWord[4]            = spareFlag;
  end

  always_comb begin
    busRdata = '0;
    if (busSel && !busWr) begin
      case (busAddr)
        CTRL_OFS:          busRdata = ctrlWord;
        SUM0_OFS:          busRdata = sum0;
        SUM1_OFS:          busRdata = sum1;
        SUM2_OFS:          busRdata = sum2;
        FIELD_OFS + 8'h00: busRdata = DATA_W'(curTime.sec);
        FIELD_OFS + 8'h04: busRdata = DATA_W'(curTime.min);
        FIELD_OFS + 8'h08: busRdata = DATA_W'(curTime.hour);
        FIELD_OFS + 8'h0C: busRdata = DATA_W'(curTime.mday);
        FIELD_OFS + 8'h10: busRdata = DATA_W'(curTime.wday);
        FIELD_OFS + 8'h14: busRdata = DATA_W'(curTime.yday);
        FIELD_OFS + 8'h18: busRdata = DATA_W'(curTime.mon);
        FIELD_OFS + 8'h1C: busRdata = DATA_W'(curTime.year);
        default:           busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/calendar_clock.sv
`timescale 1ns/1ps
module calendar_clock
  import calendar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata
);
  calStrobes_t strobes;
  calTime_t    curTime;
  logic        runEn;
  logic        spareFlag;
  logic        unusedWdata;

  assign unusedWdata = ^{busWdata[DATA_W-1:YEAR_W]};

  calendar_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .busSel     (busSel),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .runBitIn   (busWdata[0]),
    .spareBitIn (busWdata[4]),
    .strobes    (strobes),
    .runEn      (runEn),
    .spareFlag  (spareFlag)
  );

  calendar_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (busWdata[YEAR_W-1:0]),
    .curTime (curTime)
  );

  calendar_readout u_rd (
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .curTime   (curTime),
    .runEn     (runEn),
    .spareFlag (spareFlag),
    .busRdata  (busRdata)
  );
endmodule

// File: rtl/calendar_clock_chk.sv
`timescale 1ns/1ps
module calendar_clock_chk (
  input logic        clk,
  input logic        rstN,
  input logic        tick,
  input logic        busSel,
  input logic        busWr,
  input logic [7:0]  busAddr,
  input logic [31:0] busRdata,
  input logic [5:0]  curSec,
  input logic [5:0]  curMin,
  input logic [4:0]  curHour,
  input logic        runEn,
  input logic        spareFlag
);
  logic anyWrite;
  assign anyWrite = busSel && busWr;

  // R2
  frozen_when_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !anyWrite) |=> ($stable(curSec) && $stable(curMin) && $stable(curHour)));

  // R5
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && tick && !anyWrite && curSec == 6'd59) |=> (curSec == 6'd0));

  // R5
  min_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && tick && !anyWrite && curSec == 6'd59 && curMin == 6'd59) |=> (curMin == 6'd0));

  // R6
  hour_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && tick && !anyWrite && curSec == 6'd59 && curMin == 6'd59 && curHour == 5'd23)
      |=> (curHour == 5'd0));

  // R3
  ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == 8'h08) |-> (busRdata == {27'd0, spareFlag, 3'd0, runEn}));

  // R9
  sum0_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == 8'h14)
      |-> (busRdata[31:27] == 5'd0 && busRdata[23:21] == 3'd0 &&
           busRdata[15:14] == 2'd0 && busRdata[7:6] == 2'd0));
endmodule

bind calendar_clock calendar_clock_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .busSel    (busSel),
  .busWr     (busWr),
  .busAddr   (busAddr),
  .busRdata  (busRdata),
  .curSec    (curTime.sec),
  .curMin    (curTime.min),
  .curHour   (curTime.hour),
  .runEn     (runEn),
  .spareFlag (spareFlag)
);

// File: tb/calendar_clock_bench.sv
`timescale 1ns/1ps
module calendar_clock_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;

  int checks = 0;
  int errors = 0;

  calendar_clock u_calendar_clock (
    .clk(clk), .rstN(rstN), .tick(tick), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #2 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic int dimRef(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int ed, em, ey, edoy, edow;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, R13 unmapped offset
    rd(8'h08, d); chk("R1 ctrl", d, 32'h0);
    rd(8'h14, d); chk("R1 sum0", d, 32'h0);
    rd(8'h18, d); chk("R1 sum1", d, 32'h0000_0101);
    rd(8'h1C, d); chk("R1 sum2", d, 32'h1);
    rd(8'h00, d); chk("R13 unmapped 0x00", d, 32'h0);
    rd(8'h40, d); chk("R13 unmapped 0x40", d, 32'h0);

    // R4 field widths and offsets
    for (int i = 0; i < 8; i++) begin
      logic [31:0] mask;
      case (i)
        0, 1: mask = 32'h3F;
        2, 3: mask = 32'h1F;
        4:    mask = 32'h7;
        5:    mask = 32'h1FF;
        6:    mask = 32'hF;
        default: mask = 32'hFFF;
      endcase
      wr(8'h20 + 8'(4 * i), 32'hFFFF_FFFF);
      rd(8'h20 + 8'(4 * i), d); chk("R4 field ones", d, mask);
      wr(8'h20 + 8'(4 * i), 32'h0000_0A5A & mask);
      rd(8'h20 + 8'(4 * i), d); chk("R4 field pattern", d, 32'h0000_0A5A & mask);
    end

    // R2 freeze, R3 spare flag
    wr(8'h08, 32'h10);
    wr(8'h20, 32'd17);
    repeat (5) pulse();
    rd(8'h20, d); chk("R2 stopped seconds", d, 32'd17);
    rd(8'h08, d); chk("R3 spare readback", d, 32'h10);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R3 ctrl unused bits", d, 32'h11);
    pulse();
    rd(8'h20, d); chk("R3 counting with spare set", d, 32'd18);
    wr(8'h08, 32'h1);
    pulse();
    rd(8'h20, d); chk("R3 counting with spare clear", d, 32'd19);

    // R11 summary words read-only
    wr(8'h08, 32'h0);
    wr(8'h14, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R11 seconds kept", d, 32'd19);
    rd(8'h3C, d); chk("R11 year kept", d, 32'h0A5A & 32'hFFF);
    rd(8'h34, d); chk("R11 yday kept", d, 32'h05A);

    // R5 R9 seconds/minutes/hours sweep
    wr(8'h20, 0); wr(8'h24, 0); wr(8'h28, 0); wr(8'h30, 3);
    wr(8'h08, 32'h1);
    for (int n = 1; n <= 3700; n++) begin
      int es, emin, eh;
      pulse();
      es = n % 60; emin = (n / 60) % 60; eh = n / 3600;
      rd(8'h14, d);
      chk("R5 R9 sum0 sweep", d, (32'd3 << 24) | (32'(eh) << 16) | (32'(emin) << 8) | 32'(es));
    end

    // R12 write coinciding with tick
    wr(8'h20, 59); wr(8'h24, 5);
    @(negedge clk);
    tick = 1'b1; busSel = 1'b1; busWr = 1'b1; busAddr = 8'h20; busWdata = 32'd20;
    @(negedge clk);
    tick = 1'b0; busSel = 1'b0; busWr = 1'b0;
    rd(8'h20, d); chk("R12 written seconds win", d, 32'd20);
    rd(8'h24, d); chk("R12 minutes carry from old seconds", d, 32'd6);

    // R6 R7 R8 R10 day-by-day walk over a common and a leap year
    ey = 2023; em = 1; ed = 1; edoy = 1; edow = 0;
    wr(8'h3C, 32'(ey)); wr(8'h38, 32'(em)); wr(8'h2C, 32'(ed));
    wr(8'h34, 32'(edoy)); wr(8'h30, 32'(edow));
    for (int n = 0; n < 731; n++) begin
      wr(8'h20, 59); wr(8'h24, 59); wr(8'h28, 23);
      pulse();
      edow = (edow == 6) ? 0 : edow + 1;
      if (ed >= dimRef(em, ey)) begin
        ed = 1;
        if (em == 12) begin em = 1; ey++; edoy = 1; end
        else begin em++; edoy++; end
      end else begin
        ed++; edoy++;
      end
      rd(8'h18, d);
      chk("R7 R8 R10 sum1 date", d, (32'(ey) << 16) | (32'(em) << 8) | 32'(ed));
      rd(8'h1C, d); chk("R8 R10 day of year", d, 32'(edoy));
      rd(8'h14, d); chk("R6 R9 weekday and midnight", d, 32'(edow) << 24);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule